// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

A counter of configurable width that either steps upward on a divided-down system clock or follows a two-phase incremental position sensor. Four counting functions are available: a plain timer driven by the prescaler, two half-resolution decoders that step on every transition of one phase while the level of the other phase picks the direction, and a full-resolution decoder that steps on every transition of either phase. The count runs between zero and a programmable ceiling. It wraps in both directions, and every wrap raises a sticky flag and a one-cycle pulse.

Software drives the block through a write-only register port. The port carries a control word (run, ceiling buffering, function select), a direct count load, the ceiling, the prescaler ratio, a refresh command and a flag acknowledge. The count, the last direction, the flag and the pulse are visible as output pins. Both phase inputs are sampled by the block's clock, so a transition at the pins affects the count at the second rising edge after it.

Top module: `qtc_top`

## Requirements
- R1: After reset the count is 0, the direction bit is 0, the flag and pulse are 0, the ceiling is all ones, the prescaler ratio field is 0 and the counter is stopped in function 0.
- R2: Function 0 (control bits [4:2] = 0) with run (control bit 0) set steps the count up by one on each prescaler tick and ignores both phase inputs.
- R3: A prescaler field value N (address 3) gives one tick every N+1 clocks. A newly written value takes effect only at the next wrap or refresh.
- R4: Function 1 steps on each transition of phase A: down when A and B are equal after the transition, up otherwise.
- R5: Function 2 steps on each transition of phase B: up when A and B are equal after the transition, down otherwise.
- R6: Function 3 steps on a transition of either phase, with the same direction rules as R4 and R5. A clock in which both phases change gives no step.
- R7: The direction bit is 1 after a downward step and 0 after an upward step, and it holds between steps.
- R8: An upward step from a count equal to the ceiling gives 0, sets the flag and gives a one-clock pulse.
- R9: A downward step from 0 gives the ceiling, sets the flag and gives a one-clock pulse.
- R10: With ceiling buffering off (control bit 1 = 0), a ceiling write (address 2) applies at once. With buffering on, it applies at the next wrap or refresh.
- R11: A write to address 4 (refresh) clears the count and the prescaler counter and loads the pending prescaler and ceiling values.
- R12: With run clear, or with a function code of 4 to 7, the count never changes except through loads and refresh.
- R13: A write to address 1 loads the count on the next clock. A write to address 5 clears the flag, unless a wrap in the same clock sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | CNT_W | Write data |
| qa | input | 1 | Encoder phase A |
| qb | input | 1 | Encoder phase B |
| count | output | CNT_W | Current count |
| dirDown | output | 1 | 1 after a downward step |
| updFlag | output | 1 | Sticky wrap flag |
| updPulse | output | 1 | One-clock wrap pulse |

## Verification
The hardest case to reach is a buffered ceiling that must stay unused until a wrap, while the wrap itself depends on the old ceiling and on a prescaler value that has not yet taken effect. The stimulus sets a small old ceiling, turns buffering on, writes a different ceiling and a new ratio, and then lets the counter run through a wrap. A reference model checks every clock that the count uses the old limit first and the new one afterwards. The downward wrap in decoder mode is reached by driving the phases backwards from a count of zero.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_COUNT   = 3'd1;
  localparam logic [2:0] ADDR_CEIL    = 3'd2;
  localparam logic [2:0] ADDR_PSC     = 3'd3;
  localparam logic [2:0] ADDR_REFRESH = 3'd4;
  localparam logic [2:0] ADDR_ACK     = 3'd5;

  localparam logic [2:0] FN_CLOCK  = 3'd0;
  localparam logic [2:0] FN_EDGE_A = 3'd1;
  localparam logic [2:0] FN_EDGE_B = 3'd2;
  localparam logic [2:0] FN_BOTH   = 3'd3;

  typedef struct packed {
    logic step;
    logic down;
    logic refresh;
    logic load;
    logic ack;
  } strobeT;
endpackage

// File: rtl/qtc_ctrl.sv
module qtc_ctrl
  import qtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             qa,
  input  logic             qb,
  input  logic             wrapEv,
  output logic [CNT_W-1:0] ceilAct,
  output logic [CNT_W-1:0] loadVal,
  output strobeT           strb
);
  localparam int NCH = 2;

  logic             runEn, bufCeil;
  logic [2:0]       fnSel;
  logic [CNT_W-1:0] ceilReg;
  logic [PSC_W-1:0] pscReg, pscAct, pscCnt;
  logic [NCH-1:0]   qIn, qLvl, qEdge;
  logic             tick, wrCtrl, wrCeil, wrPsc, doRefresh, doUpdate;

  assign qIn = {qb, qa};

  for (genvar g = 0; g < NCH; g++) begin : gSync
    logic sNow, sOld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sNow <= 1'b0;
        sOld <= 1'b0;
      end else begin
        sNow <= qIn[g];
        sOld <= sNow;
      end
    end
    assign qLvl[g]  = sNow;
    assign qEdge[g] = sNow ^ sOld;
  end

  assign wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
  assign wrCeil    = wrEn && (wrAddr == ADDR_CEIL);
  assign wrPsc     = wrEn && (wrAddr == ADDR_PSC);
  assign doRefresh = wrEn && (wrAddr == ADDR_REFRESH);
  assign doUpdate  = doRefresh || wrapEv;
  assign tick      = (pscCnt == pscAct);

  always_comb begin
    strb         = '0;
    strb.refresh = doRefresh;
    strb.load    = wrEn && (wrAddr == ADDR_COUNT);
    strb.ack     = wrEn && (wrAddr == ADDR_ACK);
    unique case (fnSel)
      FN_CLOCK: begin
        strb.step = runEn && tick;
        strb.down = 1'b0;
      end
      FN_EDGE_A: begin
        strb.step = runEn && qEdge[0];
        strb.down = (qLvl[0] == qLvl[1]);
      end
      FN_EDGE_B: begin
        strb.step = runEn && qEdge[1];
        strb.down = (qLvl[0] != qLvl[1]);
      end
      FN_BOTH: begin
        strb.step = runEn && (qEdge[0] ^ qEdge[1]);
        strb.down = qEdge[0] ? (qLvl[0] == qLvl[1]) : (qLvl[0] != qLvl[1]);
      end
      default: begin
        strb.step = 1'b0;
        strb.down = 1'b0;
      end
    endcase
  end

  assign loadVal = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      bufCeil <= 1'b0;
      fnSel   <= FN_CLOCK;
      pscReg  <= '0;
      ceilReg <= '1;
    end else begin
      if (wrCtrl) begin
        runEn   <= wrData[0];
        bufCeil <= wrData[1];
        fnSel   <= wrData[4:2];
      end
      if (wrPsc)  pscReg  <= wrData[PSC_W-1:0];
      if (wrCeil) ceilReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceilAct <= '1;
      pscAct  <= '0;
      pscCnt  <= '0;
    end else begin
      if (doUpdate) begin
        ceilAct <= ceilReg;
        pscAct  <= pscReg;
      end
      if (wrCeil && !bufCeil) ceilAct <= wrData;
      if (doRefresh) pscCnt <= '0;
      else if (runEn && fnSel == FN_CLOCK) pscCnt <= tick ? '0 : pscCnt + 1'b1;
    end
  end

  // R12
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn || fnSel > FN_BOTH) |-> !strb.step);

  // R2
  clock_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fnSel == FN_CLOCK && strb.step) |-> !strb.down);

  // R10
  ceil_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufCeil && !doUpdate) |=> $stable(ceilAct));
endmodule

// File: rtl/qtc_datapath.sv
module qtc_datapath
  import qtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] ceil,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             updFlag,
  output logic             updPulse,
  output logic             wrapEv
);
  logic liveStep, atLimit;

  assign liveStep = strb.step && !strb.refresh && !strb.load;
  assign atLimit  = strb.down ? (count == '0) : (count == ceil);
  assign wrapEv   = liveStep && atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      dirDown  <= 1'b0;
      updFlag  <= 1'b0;
      updPulse <= 1'b0;
    end else begin
      if (strb.refresh)   count <= '0;
      else if (strb.load) count <= loadVal;
      else if (strb.step) begin
        if (strb.down) count <= atLimit ? ceil : count - 1'b1;
        else           count <= atLimit ? '0   : count + 1'b1;
      end
      if (liveStep) dirDown <= strb.down;
      if (wrapEv)        updFlag <= 1'b1;
      else if (strb.ack) updFlag <= 1'b0;
      updPulse <= wrapEv;
    end
  end

  // R8
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveStep && !strb.down && count == ceil) |=> (count == '0 && updFlag && updPulse));

  // R9
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveStep && strb.down && count == '0) |=> (count == $past(ceil) && updFlag && updPulse));

  // R11
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.refresh |=> (count == '0));

  // R7
  dir_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveStep |=> (dirDown == $past(strb.down)));
endmodule

// File: rtl/qtc_top.sv
module qtc_top
  import qtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             qa,
  input  logic             qb,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             updFlag,
  output logic             updPulse
);
  strobeT           strb;
  logic [CNT_W-1:0] ceilAct, loadVal;
  logic             wrapEv;

  qtc_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .qa(qa), .qb(qb), .wrapEv(wrapEv), .ceilAct(ceilAct), .loadVal(loadVal),
    .strb(strb)
  );

  qtc_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .ceil(ceilAct),
    .count(count), .dirDown(dirDown), .updFlag(updFlag), .updPulse(updPulse),
    .wrapEv(wrapEv)
  );
endmodule

// File: tb/tb_qtc_top.sv
module tb_qtc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic        qa = 1'b0, qb = 1'b0;
  logic [15:0] count;
  logic        dirDown, updFlag, updPulse;

  int    nRun = 0, nFail = 0;
  int    phase = 0;
  string curReq = "R1";

  qtc_top dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
               .qa(qa), .qb(qb), .count(count), .dirDown(dirDown),
               .updFlag(updFlag), .updPulse(updPulse));

  always #4 clk = ~clk;

  // behavioural reference
  logic [15:0] mCnt, mCeilR, mCeilA, mPscR, mPscA, mPscC;
  logic [2:0]  mFn;
  logic        mEn, mBuf, mDir, mFlag, mPulse, mAS, mAD, mBS, mBD;

  always @(posedge clk) begin
    logic eA, eB, stp, dn, ug, ld, ack, wrp, tk;
    if (!rstN) begin
      mCnt = 0; mCeilR = 16'hFFFF; mCeilA = 16'hFFFF; mPscR = 0; mPscA = 0; mPscC = 0;
      mFn = 0; mEn = 0; mBuf = 0; mDir = 0; mFlag = 0; mPulse = 0;
      mAS = 0; mAD = 0; mBS = 0; mBD = 0;
    end else begin
      eA = mAS != mAD; eB = mBS != mBD; tk = (mPscC == mPscA);
      stp = 0; dn = 0;
      if (mEn) begin
        if (mFn == 0) stp = tk;
        else if (mFn == 1) begin stp = eA; dn = (mAS == mBS); end
        else if (mFn == 2) begin stp = eB; dn = (mAS != mBS); end
        else if (mFn == 3) begin stp = eA ^ eB; dn = eA ? (mAS == mBS) : (mAS != mBS); end
      end
      ug  = wrEn && wrAddr == 3'd4;
      ld  = wrEn && wrAddr == 3'd1;
      ack = wrEn && wrAddr == 3'd5;
      wrp = stp && !ug && !ld && (dn ? (mCnt == 0) : (mCnt == mCeilA));
      if (ug) mCnt = 0;
      else if (ld) mCnt = wrData;
      else if (stp) mCnt = wrp ? (dn ? mCeilA : 16'd0) : (dn ? mCnt - 1 : mCnt + 1);
      if (stp && !ug && !ld) mDir = dn;
      if (wrp) mFlag = 1; else if (ack) mFlag = 0;
      mPulse = wrp;
      if (ug) mPscC = 0;
      else if (mEn && mFn == 0) mPscC = tk ? 16'd0 : mPscC + 1;
      if (ug || wrp) begin mPscA = mPscR; mCeilA = mCeilR; end
      if (wrEn && wrAddr == 3'd2 && !mBuf) mCeilA = wrData;
      if (wrEn && wrAddr == 3'd2) mCeilR = wrData;
      if (wrEn && wrAddr == 3'd3) mPscR = wrData;
      if (wrEn && wrAddr == 3'd0) begin mEn = wrData[0]; mBuf = wrData[1]; mFn = wrData[4:2]; end
      mAD = mAS; mAS = qa; mBD = mBS; mBS = qb;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      nRun++;
      if (count !== mCnt || dirDown !== mDir || updFlag !== mFlag || updPulse !== mPulse) begin
        nFail++;
        $display("FAIL %s cnt/dir/flag/pulse act=%0h/%0b/%0b/%0b exp=%0h/%0b/%0b/%0b",
                 curReq, count, dirDown, updFlag, updPulse, mCnt, mDir, mFlag, mPulse);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qmove(input int d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase = (phase + d) & 3;
      qa = (phase == 1) || (phase == 2);
      qb = (phase >= 2);
      idle(3);
    end
  endtask

  task automatic direct(input string req, input logic ok, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3); rstN = 1'b1; idle(2);
    curReq = "R1";
    direct("R1", count == 0 && !updFlag && !dirDown && !updPulse, count, 0);

    curReq = "R2";
    wr(3'd2, 16'd1000);
    wr(3'd0, 16'h0001);
    for (int i = 0; i < 6; i++) begin qa = ~qa; qb = ~qb; idle(2); end
    direct("R2", count > 10, count, 11);

    curReq = "R3";
    wr(3'd3, 16'd3); idle(12);
    wr(3'd4, 16'd0);
    curReq = "R11";
    idle(1);
    direct("R11", count == 0, count, 0);
    curReq = "R3";
    idle(20);

    curReq = "R8";
    wr(3'd3, 16'd0); wr(3'd4, 16'd0);
    wr(3'd2, 16'd20); wr(3'd1, 16'd17); idle(6);
    direct("R8", updFlag, updFlag, 1);
    curReq = "R13";
    wr(3'd5, 16'd0); idle(2);
    wr(3'd1, 16'h0100); idle(1);

    curReq = "R10";
    wr(3'd1, 16'd10);
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'd7);
    wr(3'd3, 16'd1);
    idle(40);
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'd30); idle(70);

    curReq = "R12";
    wr(3'd0, 16'h0000); idle(10);
    wr(3'd0, 16'h0015);
    qmove(1, 6); idle(5);

    curReq = "R4";
    wr(3'd2, 16'd50); wr(3'd4, 16'd0);
    wr(3'd0, 16'h0005);
    qmove(1, 12);
    curReq = "R7";
    direct("R7", !dirDown, dirDown, 0);
    qmove(-1, 12);
    curReq = "R9";
    qmove(-1, 8);
    direct("R9", updFlag && dirDown, updFlag, 1);

    curReq = "R5";
    wr(3'd5, 16'd0);
    wr(3'd0, 16'h0009);
    qmove(1, 10); qmove(-1, 14);

    curReq = "R6";
    wr(3'd1, 16'd5);
    wr(3'd0, 16'h000D);
    qmove(1, 10); qmove(-1, 20);
    @(negedge clk); qa = ~qa; qb = ~qb; idle(4);
    qmove(1, 4); idle(4);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule